// File: doc/BRIEF.md
# I2C SCL Count Calculator

This block turns I2C bus timing targets into the high-count and low-count values that an SCL waveform generator needs, plus a count for the SDA hold time. All of its inputs are sampled when a start strobe is accepted. The reference clock is given as a ratio of ticks to nanoseconds, and so is the bus rate. The other inputs are the rise and fall times of the bus edges, the spike-suppression length in reference-clock cycles, and the minimum SCL high and low times for the speed mode in use. Typical minimum high/low pairs are 4000/4700 ns at 100 kHz, 600/1300 ns at 400 kHz, 260/500 ns at 1 MHz and 60/160 ns at 3.4 MHz.

The unit first converts each time target into reference-clock counts, rounding up. It also derives the bus period in counts. It then solves for the high and low counts from the edge times and the spike length. If the sum of the high and low minimums falls short of the period, the counts are stretched until the period is met exactly, and any odd count of the shortfall goes to the low side. All divisions are done by one shared iterative restoring divider, so each calculation takes a fixed number of cycles. The result is reported by a one-cycle done pulse. An error flag is raised instead when a solved count comes out negative.

Top module: `scl_count_calc`

## Requirements
- R1: After reset, busy, done and err are 0 and hcnt, lcnt and hold_cnt are 0.
- R2: Every time-to-count conversion is ceil(ref_ticks × t_ns / ref_ns). An exact quotient is not rounded up.
- R3: The period count is ceil(ref_ticks × bus_ns / (ref_ns × bus_ticks)).
- R4: Before balancing, the high count is thigh_cnt − fall_cnt − 7 − spike_len.
- R5: Before balancing, the low count is tlow_cnt − rise_cnt + fall_cnt − 1.
- R6: If either solved count is negative, done pulses with err = 1 and hcnt, lcnt and hold_cnt are driven to 0. A solved count of exactly 0 is valid.
- R7: Let total = hcnt + lcnt + 7 + spike_len + rise_cnt + 1. When total is below the period count, half the shortfall (rounded down) is added to both counts, and then the remainder is added to lcnt, so that the final total equals the period count. Otherwise the counts are left as solved.
- R8: hold_cnt is the rounded-up conversion of hold_ns, and of 300 ns when hold_ns is 0.
- R9: busy rises in the cycle after an accepted start and falls in the same cycle that done pulses. done lasts exactly one cycle and is never high together with busy. The outputs do not change while busy stays high.
- R10: A start that arrives while busy is high is ignored. The result is that of the first start, and no extra done follows.
- R11: err keeps its value until the next accepted start and clears in the cycle after it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Begin a calculation (accepted only when idle) |
| ref_ticks | input | TW | Reference clock ticks in the ratio |
| ref_ns | input | NW | Reference clock nanoseconds in the ratio |
| bus_ticks | input | TW | Bus rate ticks in the ratio |
| bus_ns | input | NW | Bus rate nanoseconds in the ratio |
| rise_ns | input | NW | Edge rise time |
| fall_ns | input | NW | Edge fall time |
| spike_len | input | SW | Spike-suppression length in reference cycles |
| thigh_ns | input | NW | Minimum SCL high time |
| tlow_ns | input | NW | Minimum SCL low time |
| hold_ns | input | NW | SDA hold time (0 selects the default) |
| busy | output | 1 | Calculation in progress |
| done | output | 1 | One-cycle completion pulse |
| err | output | 1 | A solved count was negative |
| hcnt | output | CW | High count |
| lcnt | output | CW | Low count |
| hold_cnt | output | CW | SDA hold count |

## Verification
Each scenario is chosen for a specific way the arithmetic can go wrong. One case has an odd shortfall, which exposes a design that splits the remainder evenly or gives it to the high side: the period total would then miss by one, or hcnt would be off by one. Other cases check that exact quotients stay exact, which catches a divider that always adds one; a design that truncates instead would come out one low on the fractional conversions. A case with a high count of exactly zero must pass, while cases with a large spike or a large rise must raise err and produce zero counts. This separates a correct sign test from one that is off by one or that wraps. A second start while busy must leave the first result untouched, so a design that restarts or re-samples its inputs fails.

// File: rtl/scl_calc_pkg.sv
package scl_calc_pkg;

   // order of the conversions run through the shared divider
   typedef enum logic [2:0] {
      CV_PERIOD = 3'd0,
      CV_RISE   = 3'd1,
      CV_FALL   = 3'd2,
      CV_TLOW   = 3'd3,
      CV_THIGH  = 3'd4,
      CV_HOLD   = 3'd5
   } conv_e;

   localparam int NUM_CONV = 6;

   // fixed overheads of the SCL generator in reference cycles
   localparam int HIGH_OVERHEAD = 7;
   localparam int LOW_OVERHEAD  = 1;

   typedef enum logic [1:0] {
      ST_IDLE  = 2'd0,
      ST_ISSUE = 2'd1,
      ST_WAIT  = 2'd2,
      ST_FIN   = 2'd3
   } calc_state_e;

endpackage

// File: rtl/scl_ceil_div.sv
module scl_ceil_div #(
   parameter int PW = 40
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          start,
   input  logic [PW-1:0] dividend,
   input  logic [PW-1:0] divisor,
   output logic          done,
   output logic [PW-1:0] quot
);
   localparam int STW = $clog2(PW + 1);

   logic [PW:0]    acc;
   logic [PW-1:0]  q;
   logic [PW-1:0]  dvs;
   logic [STW-1:0] left;
   logic           run;
   logic [PW:0]    shifted;
   logic           fits;

   // one restoring step: bring the next dividend bit into the remainder
   always_comb begin
      shifted = {acc[PW-1:0], q[PW-1]};
      fits    = (shifted >= {1'b0, dvs});
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         acc  <= '0;
         q    <= '0;
         dvs  <= '0;
         left <= '0;
         run  <= 1'b0;
         done <= 1'b0;
      end else begin
         done <= 1'b0;
         if (start) begin
            acc  <= '0;
            q    <= dividend;
            dvs  <= divisor;
            left <= STW'(PW);
            run  <= 1'b1;
         end else if (run) begin
            acc  <= fits ? (shifted - {1'b0, dvs}) : shifted;
            q    <= {q[PW-2:0], fits};
            left <= left - 1'b1;
            if (left == STW'(1)) begin
               run  <= 1'b0;
               done <= 1'b1;
            end
         end
      end
   end

   // any remainder rounds the quotient up
   assign quot = q + PW'(acc != '0);

endmodule

// File: rtl/scl_operand_sel.sv
module scl_operand_sel
   import scl_calc_pkg::*;
#(
   parameter int TW = 16,
   parameter int NW = 24,
   parameter int PW = TW + NW,
   parameter int DEFAULT_HOLD_NS = 300
) (
   input  conv_e         sel,
   input  logic [TW-1:0] ref_ticks,
   input  logic [NW-1:0] ref_ns,
   input  logic [TW-1:0] bus_ticks,
   input  logic [NW-1:0] bus_ns,
   input  logic [NW-1:0] rise_ns,
   input  logic [NW-1:0] fall_ns,
   input  logic [NW-1:0] thigh_ns,
   input  logic [NW-1:0] tlow_ns,
   input  logic [NW-1:0] hold_ns,
   output logic [PW-1:0] dividend,
   output logic [PW-1:0] divisor
);
   logic [NW-1:0] time_ns;
   logic [NW-1:0] hold_eff;

   always_comb begin
      hold_eff = (hold_ns == '0) ? NW'(DEFAULT_HOLD_NS) : hold_ns;
      unique case (sel)
         CV_PERIOD: time_ns = bus_ns;
         CV_RISE:   time_ns = rise_ns;
         CV_FALL:   time_ns = fall_ns;
         CV_TLOW:   time_ns = tlow_ns;
         CV_THIGH:  time_ns = thigh_ns;
         default:   time_ns = hold_eff;
      endcase
      dividend = PW'(ref_ticks) * PW'(time_ns);
      if (sel == CV_PERIOD)
         divisor = PW'(ref_ns) * PW'(bus_ticks);
      else
         divisor = PW'(ref_ns);
   end

endmodule

// File: rtl/scl_solve.sv
module scl_solve
   import scl_calc_pkg::*;
#(
   parameter int CW = 24,
   parameter int SW = 8
) (
   input  logic signed [CW-1:0] period_cnt,
   input  logic signed [CW-1:0] rise_cnt,
   input  logic signed [CW-1:0] fall_cnt,
   input  logic signed [CW-1:0] tlow_cnt,
   input  logic signed [CW-1:0] thigh_cnt,
   input  logic        [SW-1:0] spike_len,
   output logic signed [CW-1:0] hcnt,
   output logic signed [CW-1:0] lcnt,
   output logic                 negative
);
   localparam logic signed [CW-1:0] HOV = CW'(HIGH_OVERHEAD);
   localparam logic signed [CW-1:0] LOV = CW'(LOW_OVERHEAD);

   logic signed [CW-1:0] spk;
   logic signed [CW-1:0] h0, l0, tot0, half, h1, l1, tot1;

   always_comb begin
      spk  = $signed(CW'(spike_len));
      // back-solve from the edge times
      h0   = thigh_cnt - fall_cnt - HOV - spk;
      l0   = tlow_cnt - rise_cnt + fall_cnt - LOV;
      negative = h0[CW-1] | l0[CW-1];
      tot0 = h0 + l0 + HOV + spk + rise_cnt + LOV;
      half = '0;
      h1   = h0;
      l1   = l0;
      tot1 = tot0;
      if (tot0 < period_cnt) begin
         // stretch both sides equally, odd count to the low side
         half = (period_cnt - tot0) >>> 1;
         h1   = h0 + half;
         l1   = l0 + half;
         tot1 = h1 + l1 + HOV + spk + rise_cnt + LOV;
         l1   = l1 + (period_cnt - tot1);
      end
      hcnt = h1;
      lcnt = l1;
   end

endmodule

// File: rtl/scl_count_calc.sv
module scl_count_calc
   import scl_calc_pkg::*;
#(
   parameter int TW = 16,
   parameter int NW = 24,
   parameter int SW = 8,
   parameter int CW = 24,
   parameter int DEFAULT_HOLD_NS = 300
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          start,
   input  logic [TW-1:0] ref_ticks,
   input  logic [NW-1:0] ref_ns,
   input  logic [TW-1:0] bus_ticks,
   input  logic [NW-1:0] bus_ns,
   input  logic [NW-1:0] rise_ns,
   input  logic [NW-1:0] fall_ns,
   input  logic [SW-1:0] spike_len,
   input  logic [NW-1:0] thigh_ns,
   input  logic [NW-1:0] tlow_ns,
   input  logic [NW-1:0] hold_ns,
   output logic          busy,
   output logic          done,
   output logic          err,
   output logic [CW-1:0] hcnt,
   output logic [CW-1:0] lcnt,
   output logic [CW-1:0] hold_cnt
);
   localparam int PW = TW + NW;

   // elaboration-time parameter checks
   if (TW < 2) begin : g_chk_tw
      $error("scl_count_calc: TW must be at least 2");
   end
   if (NW < 2) begin : g_chk_nw
      $error("scl_count_calc: NW must be at least 2");
   end
   if (CW < SW + 4 || CW > PW) begin : g_chk_cw
      $error("scl_count_calc: CW must exceed SW+3 and not exceed TW+NW");
   end
   if (DEFAULT_HOLD_NS < 1 || DEFAULT_HOLD_NS >= (1 << (NW - 1))) begin : g_chk_hold
      $error("scl_count_calc: DEFAULT_HOLD_NS out of range");
   end

   calc_state_e state;
   conv_e       idx;

   // operands captured when a start is accepted
   logic [TW-1:0] l_ref_ticks, l_bus_ticks;
   logic [NW-1:0] l_ref_ns, l_bus_ns, l_rise, l_fall, l_thigh, l_tlow, l_hold;
   logic [SW-1:0] l_spike;

   logic [PW-1:0] div_dividend, div_divisor, div_quot;
   logic          div_start, div_done;

   logic signed [CW-1:0] s_hcnt, s_lcnt;
   logic                 s_neg;

   assign busy      = (state != ST_IDLE);
   assign div_start = (state == ST_ISSUE);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         l_ref_ticks <= '0;
         l_bus_ticks <= '0;
         l_ref_ns    <= '0;
         l_bus_ns    <= '0;
         l_rise      <= '0;
         l_fall      <= '0;
         l_thigh     <= '0;
         l_tlow      <= '0;
         l_hold      <= '0;
         l_spike     <= '0;
      end else if (state == ST_IDLE && start) begin
         l_ref_ticks <= ref_ticks;
         l_bus_ticks <= bus_ticks;
         l_ref_ns    <= ref_ns;
         l_bus_ns    <= bus_ns;
         l_rise      <= rise_ns;
         l_fall      <= fall_ns;
         l_thigh     <= thigh_ns;
         l_tlow      <= tlow_ns;
         l_hold      <= hold_ns;
         l_spike     <= spike_len;
      end
   end

   scl_operand_sel #(
      .TW(TW), .NW(NW), .PW(PW), .DEFAULT_HOLD_NS(DEFAULT_HOLD_NS)
   ) u_sel (
      .sel       (idx),
      .ref_ticks (l_ref_ticks),
      .ref_ns    (l_ref_ns),
      .bus_ticks (l_bus_ticks),
      .bus_ns    (l_bus_ns),
      .rise_ns   (l_rise),
      .fall_ns   (l_fall),
      .thigh_ns  (l_thigh),
      .tlow_ns   (l_tlow),
      .hold_ns   (l_hold),
      .dividend  (div_dividend),
      .divisor   (div_divisor)
   );

   scl_ceil_div #(.PW(PW)) u_div (
      .clk      (clk),
      .rst_n    (rst_n),
      .start    (div_start),
      .dividend (div_dividend),
      .divisor  (div_divisor),
      .done     (div_done),
      .quot     (div_quot)
   );

   // one result register per conversion
   for (genvar gi = 0; gi < NUM_CONV; gi++) begin : g_cnt
      logic signed [CW-1:0] r;
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)
            r <= '0;
         else if (state == ST_WAIT && div_done && idx == conv_e'(gi))
            r <= $signed(div_quot[CW-1:0]);
      end
   end

   scl_solve #(.CW(CW), .SW(SW)) u_solve (
      .period_cnt (g_cnt[CV_PERIOD].r),
      .rise_cnt   (g_cnt[CV_RISE].r),
      .fall_cnt   (g_cnt[CV_FALL].r),
      .tlow_cnt   (g_cnt[CV_TLOW].r),
      .thigh_cnt  (g_cnt[CV_THIGH].r),
      .spike_len  (l_spike),
      .hcnt       (s_hcnt),
      .lcnt       (s_lcnt),
      .negative   (s_neg)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state    <= ST_IDLE;
         idx      <= CV_PERIOD;
         done     <= 1'b0;
         err      <= 1'b0;
         hcnt     <= '0;
         lcnt     <= '0;
         hold_cnt <= '0;
      end else begin
         done <= 1'b0;
         unique case (state)
            ST_IDLE: begin
               if (start) begin
                  err   <= 1'b0;
                  idx   <= CV_PERIOD;
                  state <= ST_ISSUE;
               end
            end
            ST_ISSUE: state <= ST_WAIT;
            ST_WAIT: begin
               if (div_done) begin
                  if (idx == CV_HOLD) begin
                     state <= ST_FIN;
                  end else begin
                     idx   <= conv_e'(idx + 3'd1);
                     state <= ST_ISSUE;
                  end
               end
            end
            default: begin
               done     <= 1'b1;
               err      <= s_neg;
               hcnt     <= s_neg ? '0 : s_hcnt;
               lcnt     <= s_neg ? '0 : s_lcnt;
               hold_cnt <= s_neg ? '0 : g_cnt[CV_HOLD].r;
               state    <= ST_IDLE;
            end
         endcase
      end
   end

endmodule

// File: rtl/scl_count_calc_chk.sv
module scl_count_calc_chk #(
   parameter int CW = 24
) (
   input logic          clk,
   input logic          rst_n,
   input logic          busy,
   input logic          done,
   input logic          err,
   input logic [CW-1:0] hcnt,
   input logic [CW-1:0] lcnt,
   input logic [CW-1:0] hold_cnt
);

   a_r9_done_single: assert property (@(posedge clk) disable iff (!rst_n)
      done |=> !done);

   a_r9_busy_done_excl: assert property (@(posedge clk) disable iff (!rst_n)
      !(busy && done));

   a_r9_busy_ends_with_done: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(busy) |-> done);

   a_r9_outputs_hold: assert property (@(posedge clk) disable iff (!rst_n)
      (busy && $past(busy)) |-> ($stable(hcnt) && $stable(lcnt) && $stable(hold_cnt)));

   a_r6_err_zero_counts: assert property (@(posedge clk) disable iff (!rst_n)
      (done && err) |-> (hcnt == '0 && lcnt == '0 && hold_cnt == '0));

   a_r11_err_rises_on_done: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(err) |-> done);

   a_r11_err_clears_on_start: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(err) |-> busy);

endmodule

bind scl_count_calc scl_count_calc_chk #(.CW(CW)) u_chk (
   .clk      (clk),
   .rst_n    (rst_n),
   .busy     (busy),
   .done     (done),
   .err      (err),
   .hcnt     (hcnt),
   .lcnt     (lcnt),
   .hold_cnt (hold_cnt)
);

// File: tb/sim_scl_count_calc.sv
module sim_scl_count_calc;
   localparam int CLK_PERIOD = 10;
   localparam int TW = 16;
   localparam int NW = 24;
   localparam int SW = 8;
   localparam int CW = 24;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          start = 1'b0;
   logic [TW-1:0] ref_ticks = '0, bus_ticks = '0;
   logic [NW-1:0] ref_ns = '0, bus_ns = '0, rise_ns = '0, fall_ns = '0;
   logic [NW-1:0] thigh_ns = '0, tlow_ns = '0, hold_ns = '0;
   logic [SW-1:0] spike_len = '0;
   logic          busy, done, err;
   logic [CW-1:0] hcnt, lcnt, hold_cnt;

   int total = 0;
   int bad = 0;

   always #(CLK_PERIOD / 2) clk = ~clk;

   scl_count_calc #(.TW(TW), .NW(NW), .SW(SW), .CW(CW)) u0 (
      .clk(clk), .rst_n(rst_n), .start(start),
      .ref_ticks(ref_ticks), .ref_ns(ref_ns), .bus_ticks(bus_ticks), .bus_ns(bus_ns),
      .rise_ns(rise_ns), .fall_ns(fall_ns), .spike_len(spike_len),
      .thigh_ns(thigh_ns), .tlow_ns(tlow_ns), .hold_ns(hold_ns),
      .busy(busy), .done(done), .err(err),
      .hcnt(hcnt), .lcnt(lcnt), .hold_cnt(hold_cnt)
   );

   task automatic check(input string req, input string what, input longint act, input longint exp);
      total++;
      if (act != exp) begin
         bad++;
         $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
      end
   endtask

   function automatic longint cdiv(input longint a, input longint b);
      return (a + b - 1) / b;
   endfunction

   // expected results straight from the requirement formulas
   task automatic model(input longint rt, rn, bt, bn, ri, fa, sp, th, tl, ho,
                        output bit e, output longint h, output longint l, output longint hc);
      longint per, rc, fc, thc, tlc, tot, d;
      per = cdiv(rt * bn, rn * bt);
      rc  = cdiv(rt * ri, rn);
      fc  = cdiv(rt * fa, rn);
      thc = cdiv(rt * th, rn);
      tlc = cdiv(rt * tl, rn);
      h   = thc - fc - 7 - sp;
      l   = tlc - rc + fc - 1;
      e   = (h < 0) || (l < 0);
      hc  = cdiv(rt * ((ho == 0) ? 300 : ho), rn);
      if (e) begin
         h = 0; l = 0; hc = 0;
         return;
      end
      tot = h + l + 7 + sp + rc + 1;
      if (tot < per) begin
         d = (per - tot) / 2;
         h += d;
         l += d;
         tot = h + l + 7 + sp + rc + 1;
         l += per - tot;
      end
   endtask

   task automatic drive(input longint rt, rn, bt, bn, ri, fa, sp, th, tl, ho);
      ref_ticks = TW'(rt); ref_ns = NW'(rn); bus_ticks = TW'(bt); bus_ns = NW'(bn);
      rise_ns = NW'(ri); fall_ns = NW'(fa); spike_len = SW'(sp);
      thigh_ns = NW'(th); tlow_ns = NW'(tl); hold_ns = NW'(ho);
   endtask

   task automatic wait_done(output bit ok);
      int n = 0;
      while (done !== 1'b1 && n < 3000) begin
         @(negedge clk);
         n++;
      end
      ok = (done === 1'b1);
   endtask

   task automatic run_case(input string req, input longint rt, rn, bt, bn, ri, fa, sp, th, tl, ho);
      bit e, ok;
      longint h, l, hc;
      model(rt, rn, bt, bn, ri, fa, sp, th, tl, ho, e, h, l, hc);
      @(negedge clk);
      drive(rt, rn, bt, bn, ri, fa, sp, th, tl, ho);
      start = 1'b1;
      @(negedge clk);
      start = 1'b0;
      check("R9", "busy after start", busy, 1);
      wait_done(ok);
      check("R9", "done seen", ok, 1);
      check("R6", {req, " err"}, err, e);
      check(req, "hcnt", hcnt, h);
      check(req, "lcnt", lcnt, l);
      check("R8", {req, " hold_cnt"}, hold_cnt, hc);
      check("R9", "busy with done", busy, 0);
      @(negedge clk);
      check("R9", "done one cycle", done, 0);
   endtask

   task automatic t_reset;
      check("R1", "busy", busy, 0);
      check("R1", "done", done, 0);
      check("R1", "err", err, 0);
      check("R1", "hcnt", hcnt, 0);
      check("R1", "lcnt", lcnt, 0);
      check("R1", "hold_cnt", hold_cnt, 0);
   endtask

   // 400 kHz bus from a 120 MHz reference, even shortfall, default hold
   task automatic t_fast_120;
      run_case("R7", 120, 1000, 400, 1000000, 100, 20, 5, 600, 1300, 0);
   endtask

   // 100 kHz from 400/3000 reference: fractional conversions, odd shortfall
   task automatic t_std_133;
      run_case("R3", 400, 3000, 100, 1000000, 250, 30, 3, 4000, 4700, 400);
      check("R7", "period met", hcnt + lcnt + 7 + 3 + cdiv(400 * 250, 3000) + 1,
            cdiv(400 * 1000000, 3000 * 100));
   endtask

   // 3.4 MHz, high count solves to exactly zero and is valid
   task automatic t_hs_zero;
      run_case("R6", 120, 1000, 3400, 1000000, 10, 0, 1, 60, 160, 0);
   endtask

   // total already above period: no balancing, exact quotients stay exact
   task automatic t_no_balance;
      run_case("R4", 120, 1000, 1, 1000, 300, 0, 0, 700, 800, 250);
      check("R5", "lcnt unbalanced", lcnt, 96 - 36 - 1);
      check("R2", "exact hold", hold_cnt, 30);
   endtask

   task automatic t_err_high;
      run_case("R6", 120, 1000, 400, 1000000, 100, 20, 80, 600, 1300, 0);
      check("R6", "err high side", err, 1);
   endtask

   task automatic t_err_low;
      run_case("R6", 120, 1000, 400, 1000000, 2000, 20, 5, 600, 1300, 0);
      check("R11", "err held after done", err, 1);
      @(negedge clk);
      start = 1'b1;
      drive(120, 1000, 400, 1000000, 100, 20, 5, 600, 1300, 0);
      @(negedge clk);
      start = 1'b0;
      check("R11", "err cleared after start", err, 0);
      begin
         bit ok;
         wait_done(ok);
      end
      @(negedge clk);
   endtask

   // second start while busy must not disturb the first calculation
   task automatic t_start_busy;
      bit e, ok;
      longint h, l, hc;
      int extra = 0;
      model(400, 3000, 100, 1000000, 250, 30, 3, 4000, 4700, 400, e, h, l, hc);
      @(negedge clk);
      drive(400, 3000, 100, 1000000, 250, 30, 3, 4000, 4700, 400);
      start = 1'b1;
      @(negedge clk);
      start = 1'b0;
      repeat (10) @(negedge clk);
      drive(120, 1000, 3400, 1000000, 10, 0, 1, 60, 160, 0);
      start = 1'b1;
      @(negedge clk);
      start = 1'b0;
      wait_done(ok);
      check("R10", "hcnt first start", hcnt, h);
      check("R10", "lcnt first start", lcnt, l);
      check("R10", "hold first start", hold_cnt, hc);
      repeat (400) begin
         @(negedge clk);
         if (done === 1'b1) extra++;
      end
      check("R10", "no extra done", extra, 0);
      check("R10", "idle afterwards", busy, 0);
   endtask

   initial begin
      #(CLK_PERIOD * 150000);
      bad++;
      total++;
      $display("FAIL watchdog expired");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

   initial begin
      repeat (3) @(negedge clk);
      t_reset();
      rst_n = 1'b1;
      @(negedge clk);
      t_fast_120();
      t_std_133();
      t_hs_zero();
      t_no_balance();
      t_err_high();
      t_err_low();
      t_start_busy();
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

endmodule